// File: doc/BRIEF.md
# Two-Phase Soft-Start Sequencer

This block is the digital stand-in for a soft-start capacitor in a power-sequencing controller. A ramp code replaces the capacitor voltage, at 40 codes per volt. The code climbs by one step at a fixed cycle rate. From it the block derives clamped reference values for three groups of regulators: the standby rails, the remaining rails and the VID rail. It also pulses arming strobes that tell undervoltage monitors when each phase has finished.

After bias reset the sequencer presets the ramp to the 1.0 V level. It runs a first ramp for the standby rails, waits for a timed pause, and runs a second ramp for the other rails. It then parks at the 1.25 V level. To enter the active state, both sleep-request inputs must be high and the main supply must be good for a qualification window. A third ramp then enables the VID regulator and the active-path gate drive, and the ramp parks at the 2.45 V level until a sleep request or a loss of the main supply. A shutdown input forces the ramp to zero. Releasing it restarts the full sequence. A VID power-good output follows the VID rail after a counted delay.

Top module: `softstart_seq`

## Requirements
- R1: While `rst` is high, `ramp_lvl` is 0, all arming strobes are low, and `act_path_on` and `vid_pgood` are low. On the first clock edge after `rst` falls, `ramp_lvl` becomes 40 (1.0 V).
- R2: During a ramp, `ramp_lvl` rises by exactly one code every STEP_CYC clock cycles and never jumps upward by more than one code.
- R3: In the first ramp, the step that would reach code 110 (2.75 V) instead pulses `arm_stby` and sets `ramp_lvl` to 50 (1.25 V). With a preset at edge 1, this pulse comes 1 + 70·STEP_CYC edges after reset release.
- R4: After the first ramp, `ramp_lvl` holds at 50 for PAUSE_CYC cycles. A second ramp then starts from 50, and its done step (60·STEP_CYC after the ramp starts) pulses `arm_rest` and parks the ramp at 50.
- R5: Each reference output is 0 when the ramp is at or below 50, equals ramp − 50 between 50 and 100, and is 50 (full scale) at or above 100. `ref_stby` tracks only during the first ramp and is full afterwards. `ref_rest` is 0 until the second ramp, tracks during it, and is full afterwards. `ref_vid` tracks during the active ramp, is full while active and is 0 otherwise.
- R6: From the standby park, the active ramp starts only after `req_ram_n`, `req_off_n` and `main_pwr_ok` have all been high for QUAL_CYC consecutive cycles. Any drop restarts the count, so `act_path_on` rises QUAL_CYC + 1 edges after the final rise.
- R7: `act_path_on` and `vid_reg_en` rise on the first cycle of the active ramp. At its done step (60·STEP_CYC later), `arm_act` pulses and `ramp_lvl` becomes 98 (2.45 V) and holds.
- R8: During the active ramp or the active park, a low `req_ram_n` or a low `main_pwr_ok` returns the block on the next edge to the standby park (ramp 50), with `act_path_on` and `vid_reg_en` low. `req_off_n` low with `req_ram_n` high has no effect.
- R9: `vid_pgood` is high only when `vid_reg_en` and `vid_rail_ok` have been high together on PG_CYC consecutive edges and both are still high. It falls in the same cycle that either one falls, and the count restarts from zero.
- R10: With `ss_hold` high, the next edge sets `ramp_lvl` to 0 and all outputs to off. The first edge after `ss_hold` falls presets the ramp to 40, and the full sequence repeats with the R3 timing.
- R11: The three arming strobes are never high together and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bias reset |
| ss_hold | input | 1 | Shutdown request; forces the ramp to zero |
| req_ram_n | input | 1 | Suspend-to-RAM request, active low |
| req_off_n | input | 1 | Soft-off request, active low |
| main_pwr_ok | input | 1 | Main 3.3 V input above its threshold |
| vid_rail_ok | input | 1 | VID rail above its power-good threshold |
| ramp_lvl | output | RW | Ramp code, 40 codes per volt |
| ref_stby | output | RW | Clamped reference for the standby rails |
| ref_rest | output | RW | Clamped reference for the remaining rails |
| ref_vid | output | RW | Clamped reference for the VID rail |
| arm_stby | output | 1 | One-cycle strobe at the end of the first ramp |
| arm_rest | output | 1 | One-cycle strobe at the end of the second ramp |
| arm_act | output | 1 | One-cycle strobe at the end of the active ramp |
| act_path_on | output | 1 | Gate drive for the active-supply pass devices |
| vid_reg_en | output | 1 | VID regulator enable |
| vid_pgood | output | 1 | Delayed VID power good |

## Verification
The bench counts the exact edge of each done strobe and of the qualification exit, so an off-by-one in any step, pause or qualification counter shows up as a wrong cycle count. It drops the main supply in the middle of qualification, where a design that failed to restart the count would open the active path early. It also drops the supply during the active ramp, where a design that ignored the drop would keep the gate drive on. A randomized stretch toggles the VID rail and the soft-off input around the power-good delay: a counter that saturated wrongly or failed to clear would raise power good too early, and a design that treated a lone soft-off request as a sleep would drop the active state. Shutdown and release are checked for a zero ramp and a restart timing identical to power-up.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RAMP1,
        ST_PAUSE,
        ST_RAMP2,
        ST_STBY,
        ST_QUAL,
        ST_RAMPA,
        ST_ACTIVE
    } ss_state_e;

    typedef struct packed {
        logic ph1;
        logic ph2;
        logic act;
    } ss_pulse_t;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Reference clamp: zero at or below lo, full (hi-lo) at or above hi.
    function automatic int track_ref(int v, int lo, int hi);
        if (v <= lo) return 0;
        if (v >= hi) return hi - lo;
        return v - lo;
    endfunction

endpackage

// File: rtl/ss_ramp_fsm.sv
module ss_ramp_fsm
    import ss_seq_pkg::*;
#(
    parameter int RW        = 8,
    parameter int STEP_CYC  = 4,
    parameter int PAUSE_CYC = 20,
    parameter int QUAL_CYC  = 50,
    parameter int LVL_PRE   = 40,
    parameter int LVL_LO    = 50,
    parameter int LVL_TOP   = 110,
    parameter int LVL_ACT   = 98
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ss_hold,
    input  logic            req_ram_n,
    input  logic            req_off_n,
    input  logic            main_pwr_ok,
    output ss_state_e       st,
    output logic [RW-1:0]   ramp,
    output ss_pulse_t       arm
);
    localparam int CMAX = max3(STEP_CYC, PAUSE_CYC, QUAL_CYC);
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] STEP_END  = CW'(STEP_CYC - 1);
    localparam logic [CW-1:0] PAUSE_END = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] QUAL_END  = CW'(QUAL_CYC - 1);
    localparam logic [RW-1:0] R_PRE  = RW'(LVL_PRE);
    localparam logic [RW-1:0] R_LO   = RW'(LVL_LO);
    localparam logic [RW-1:0] R_LAST = RW'(LVL_TOP - 1);
    localparam logic [RW-1:0] R_ACT  = RW'(LVL_ACT);

    logic [CW-1:0] cnt;
    logic          wake, drop, step_now, at_last;
    ss_state_e     done_next;
    logic [RW-1:0] done_lvl;

    always_comb begin
        wake     = req_ram_n & req_off_n & main_pwr_ok;
        drop     = ~req_ram_n | ~main_pwr_ok;
        step_now = (cnt == STEP_END);
        at_last  = (ramp == R_LAST);
        done_next = ST_STBY;
        done_lvl  = R_LO;
        if (st == ST_RAMP1) begin
            done_next = ST_PAUSE;
        end else if (st == ST_RAMPA) begin
            done_next = ST_ACTIVE;
            done_lvl  = R_ACT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_OFF;
            ramp <= '0;
            cnt  <= '0;
            arm  <= '0;
        end else begin
            arm <= '0;
            if (ss_hold) begin
                st   <= ST_OFF;
                ramp <= '0;
                cnt  <= '0;
            end else begin
                unique case (st)
                    ST_OFF: begin
                        st   <= ST_RAMP1;
                        ramp <= R_PRE;
                        cnt  <= '0;
                    end
                    ST_PAUSE: begin
                        if (cnt == PAUSE_END) begin
                            st  <= ST_RAMP2;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_STBY: begin
                        if (wake) begin
                            st  <= ST_QUAL;
                            cnt <= '0;
                        end
                    end
                    ST_QUAL: begin
                        if (!wake) begin
                            st  <= ST_STBY;
                            cnt <= '0;
                        end else if (cnt == QUAL_END) begin
                            st  <= ST_RAMPA;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_ACTIVE: begin
                        if (drop) begin
                            st   <= ST_STBY;
                            ramp <= R_LO;
                            cnt  <= '0;
                        end
                    end
                    default: begin
                        if (st == ST_RAMPA && drop) begin
                            st   <= ST_STBY;
                            ramp <= R_LO;
                            cnt  <= '0;
                        end else if (!step_now) begin
                            cnt <= cnt + CW'(1);
                        end else begin
                            cnt <= '0;
                            if (!at_last) begin
                                ramp <= ramp + RW'(1);
                            end else begin
                                ramp    <= done_lvl;
                                st      <= done_next;
                                arm.ph1 <= (st == ST_RAMP1);
                                arm.ph2 <= (st == ST_RAMP2);
                                arm.act <= (st == ST_RAMPA);
                            end
                        end
                    end
                endcase
            end
        end
    end

    // R2: upward motion is one code at a time, except the preset jump
    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ramp > $past(ramp) && $past(st) != ST_OFF) |-> ramp == $past(ramp) + RW'(1));

    // R3: first done strobe coincides with the snap to the low level
    p_snap_low_r3: assert property (@(posedge clk) disable iff (rst)
        arm.ph1 |-> (ramp == R_LO && st == ST_PAUSE));

    // R7: active done strobe coincides with the active park level
    p_park_act_r7: assert property (@(posedge clk) disable iff (rst)
        arm.act |-> ramp == R_ACT);

    // R8: a suspend request in the active park returns to standby
    p_sleep_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACTIVE && !req_ram_n && !ss_hold) |=> (st == ST_STBY && ramp == R_LO));

    // R10: shutdown zeroes the ramp on the next edge
    p_shutdown_r10: assert property (@(posedge clk) disable iff (rst)
        ss_hold |=> ramp == '0);

    // R11: strobes never overlap
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(arm));

endmodule

// File: rtl/ss_ref_map.sv
module ss_ref_map
    import ss_seq_pkg::*;
#(
    parameter int RW     = 8,
    parameter int LVL_LO = 50,
    parameter int LVL_HI = 100
) (
    input  ss_state_e     st,
    input  logic [RW-1:0] ramp,
    output logic [RW-1:0] ref_stby,
    output logic [RW-1:0] ref_rest,
    output logic [RW-1:0] ref_vid
);
    localparam logic [RW-1:0] FULL = RW'(LVL_HI - LVL_LO);

    logic [RW-1:0] trk;

    always_comb begin
        trk = RW'(track_ref(int'(ramp), LVL_LO, LVL_HI));

        unique case (st)
            ST_OFF:   ref_stby = '0;
            ST_RAMP1: ref_stby = trk;
            default:  ref_stby = FULL;
        endcase

        unique case (st)
            ST_OFF, ST_RAMP1, ST_PAUSE: ref_rest = '0;
            ST_RAMP2:                   ref_rest = trk;
            default:                    ref_rest = FULL;
        endcase

        unique case (st)
            ST_RAMPA:  ref_vid = trk;
            ST_ACTIVE: ref_vid = FULL;
            default:   ref_vid = '0;
        endcase
    end

endmodule

// File: rtl/ss_vid_pg.sv
module ss_vid_pg #(
    parameter int PG_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic vid_en,
    input  logic vid_ok,
    output logic pg
);
    localparam int PW = $clog2(PG_CYC + 1);
    localparam logic [PW-1:0] PG_END = PW'(PG_CYC);

    logic [PW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst || !(vid_en && vid_ok)) begin
            dcnt <= '0;
        end else if (dcnt != PG_END) begin
            dcnt <= dcnt + PW'(1);
        end
    end

    always_comb pg = (dcnt == PG_END) && vid_en && vid_ok;

    // R9: power good can only rise after a cycle with the rail qualified
    p_pg_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(pg) |-> $past(vid_en && vid_ok));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_seq_pkg::*;
#(
    parameter int RW        = 8,
    parameter int STEP_CYC  = 4,
    parameter int PAUSE_CYC = 20,
    parameter int QUAL_CYC  = 50,
    parameter int PG_CYC    = 12,
    parameter int LVL_PRE   = 40,
    parameter int LVL_LO    = 50,
    parameter int LVL_HI    = 100,
    parameter int LVL_TOP   = 110,
    parameter int LVL_ACT   = 98
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ss_hold,
    input  logic          req_ram_n,
    input  logic          req_off_n,
    input  logic          main_pwr_ok,
    input  logic          vid_rail_ok,
    output logic [RW-1:0] ramp_lvl,
    output logic [RW-1:0] ref_stby,
    output logic [RW-1:0] ref_rest,
    output logic [RW-1:0] ref_vid,
    output logic          arm_stby,
    output logic          arm_rest,
    output logic          arm_act,
    output logic          act_path_on,
    output logic          vid_reg_en,
    output logic          vid_pgood
);
    localparam logic [RW-1:0] FULL = RW'(LVL_HI - LVL_LO);

    ss_state_e st;
    ss_pulse_t arm;

    ss_ramp_fsm #(
        .RW(RW), .STEP_CYC(STEP_CYC), .PAUSE_CYC(PAUSE_CYC), .QUAL_CYC(QUAL_CYC),
        .LVL_PRE(LVL_PRE), .LVL_LO(LVL_LO), .LVL_TOP(LVL_TOP), .LVL_ACT(LVL_ACT)
    ) u_fsm (
        .clk(clk), .rst(rst), .ss_hold(ss_hold),
        .req_ram_n(req_ram_n), .req_off_n(req_off_n), .main_pwr_ok(main_pwr_ok),
        .st(st), .ramp(ramp_lvl), .arm(arm)
    );

    ss_ref_map #(
        .RW(RW), .LVL_LO(LVL_LO), .LVL_HI(LVL_HI)
    ) u_ref (
        .st(st), .ramp(ramp_lvl),
        .ref_stby(ref_stby), .ref_rest(ref_rest), .ref_vid(ref_vid)
    );

    always_comb begin
        arm_stby    = arm.ph1;
        arm_rest    = arm.ph2;
        arm_act     = arm.act;
        act_path_on = (st == ST_RAMPA) || (st == ST_ACTIVE);
        vid_reg_en  = act_path_on;
    end

    ss_vid_pg #(.PG_CYC(PG_CYC)) u_pg (
        .clk(clk), .rst(rst), .vid_en(vid_reg_en), .vid_ok(vid_rail_ok), .pg(vid_pgood)
    );

    // R5: no reference ever exceeds full scale
    p_ref_range_r5: assert property (@(posedge clk) disable iff (rst)
        (ref_stby <= FULL) && (ref_rest <= FULL) && (ref_vid <= FULL));

endmodule

// File: tb/softstart_seq_test.sv
module softstart_seq_test;
    localparam int S  = 4;
    localparam int P  = 20;
    localparam int Q  = 50;
    localparam int PG = 12;

    logic clk = 1'b0;
    logic rst, ss_hold, req_ram_n, req_off_n, main_pwr_ok, vid_rail_ok;
    logic [7:0] ramp_lvl, ref_stby, ref_rest, ref_vid;
    logic arm_stby, arm_rest, arm_act, act_path_on, vid_reg_en, vid_pgood;

    int nchk = 0;
    int nbad = 0;
    int bad11 = 0;
    int cycles = 0;
    logic prev_any = 1'b0;

    always #2 clk = ~clk;

    softstart_seq #(
        .RW(8), .STEP_CYC(S), .PAUSE_CYC(P), .QUAL_CYC(Q), .PG_CYC(PG),
        .LVL_PRE(40), .LVL_LO(50), .LVL_HI(100), .LVL_TOP(110), .LVL_ACT(98)
    ) uut (
        .clk(clk), .rst(rst), .ss_hold(ss_hold), .req_ram_n(req_ram_n),
        .req_off_n(req_off_n), .main_pwr_ok(main_pwr_ok), .vid_rail_ok(vid_rail_ok),
        .ramp_lvl(ramp_lvl), .ref_stby(ref_stby), .ref_rest(ref_rest), .ref_vid(ref_vid),
        .arm_stby(arm_stby), .arm_rest(arm_rest), .arm_act(arm_act),
        .act_path_on(act_path_on), .vid_reg_en(vid_reg_en), .vid_pgood(vid_pgood)
    );

    function automatic int exp_ref(int r);
        if (r <= 50) return 0;
        if (r >= 100) return 50;
        return r - 50;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    endtask

    // R11 monitor: strobes exclusive and single-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if ($countones({arm_stby, arm_rest, arm_act}) > 1) bad11++;
            if ((arm_stby | arm_rest | arm_act) && prev_any) bad11++;
            prev_any <= arm_stby | arm_rest | arm_act;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
            finish_run();
        end
    end

    // sequence from release to the first done strobe; returns edge count
    task automatic run_phase1(string tag);
        int n = 0;
        bit seen = 0;
        while (!seen && n < 5000) begin
            cyc();
            n++;
            if (n == 1) chk(ramp_lvl == 40, {tag, " preset level"}, ramp_lvl, 40);
            if (n == 10*S) chk(ramp_lvl == 49, "R2 ramp before step", ramp_lvl, 49);
            if (n == 1 + 10*S) chk(ramp_lvl == 50, "R2 ramp after step", ramp_lvl, 50);
            seen = arm_stby;
            if (!seen) begin
                chk(ref_stby == 8'(exp_ref(ramp_lvl)), "R5 ref_stby tracking", ref_stby, exp_ref(ramp_lvl));
                chk(ref_rest == 0, "R5 ref_rest off in phase 1", ref_rest, 0);
            end
        end
        chk(n == 1 + 70*S, {tag, " first done timing"}, n, 1 + 70*S);
        chk(ramp_lvl == 50, "R3 snap to low level", ramp_lvl, 50);
    endtask

    initial begin
        int n;
        bit seen;
        int mcnt;
        bit en_b, ok_b;
        bit exp_pg;
        void'($urandom(32'd2718));

        rst = 1; ss_hold = 0; req_ram_n = 1; req_off_n = 1; main_pwr_ok = 0; vid_rail_ok = 0;
        repeat (4) cyc();
        chk(ramp_lvl == 0, "R1 reset ramp", ramp_lvl, 0);
        chk(!arm_stby && !arm_rest && !arm_act, "R1 reset strobes", arm_stby, 0);
        chk(!act_path_on && !vid_pgood, "R1 reset gate/pg", act_path_on, 0);
        rst = 0;

        run_phase1("R1 R3");

        // R4: pause then second ramp
        n = 0; seen = 0;
        while (!seen && n < 5000) begin
            cyc();
            n++;
            if (n == P + S - 1) chk(ramp_lvl == 50, "R4 hold through pause", ramp_lvl, 50);
            if (n == P + S) chk(ramp_lvl == 51, "R4 second ramp first step", ramp_lvl, 51);
            seen = arm_rest;
            if (!seen) begin
                chk(ref_stby == 50, "R5 ref_stby full after phase 1", ref_stby, 50);
                chk(ref_rest == 8'(exp_ref(ramp_lvl)), "R5 ref_rest tracking", ref_rest, exp_ref(ramp_lvl));
            end
        end
        chk(n == P + 60*S, "R4 second done timing", n, P + 60*S);
        chk(ramp_lvl == 50, "R4 park level", ramp_lvl, 50);

        repeat (100) cyc();
        chk(ramp_lvl == 50 && !act_path_on, "R6 no wake without main supply", act_path_on, 0);
        chk(ref_rest == 50 && ref_vid == 0, "R5 parked references", ref_rest, 50);

        // R6: qualification with a glitch
        main_pwr_ok = 1;
        repeat (30) cyc();
        main_pwr_ok = 0;
        cyc();
        main_pwr_ok = 1;
        n = 0;
        while (!act_path_on && n < 5000) begin
            cyc();
            n++;
        end
        chk(n == Q + 1, "R6 qualification restart timing", n, Q + 1);
        chk(vid_reg_en == 1, "R7 VID enable with active ramp", vid_reg_en, 1);

        // R7 R8 R9: active ramp with random VID rail and soft-off toggles
        mcnt = 0; seen = 0;
        for (int i = 1; i <= 400; i++) begin
            vid_rail_ok = ($urandom % 8) != 0;
            req_off_n = ($urandom % 3) != 0;
            en_b = vid_reg_en;
            ok_b = vid_rail_ok;
            cyc();
            if (en_b && ok_b) mcnt = (mcnt < PG) ? mcnt + 1 : PG;
            else mcnt = 0;
            exp_pg = (mcnt == PG) && vid_reg_en && vid_rail_ok;
            chk(vid_pgood == exp_pg, "R9 power-good delay", vid_pgood, exp_pg);
            if (arm_act) begin
                chk(i == 60*S, "R7 active done timing", i, 60*S);
                seen = 1;
            end
            if (seen) begin
                chk(ramp_lvl == 98, "R7 active park level", ramp_lvl, 98);
                chk(act_path_on == 1, "R8 soft-off alone ignored", act_path_on, 1);
                chk(ref_vid == 50, "R5 ref_vid full when active", ref_vid, 50);
            end else begin
                chk(ref_vid == 8'(exp_ref(ramp_lvl)), "R5 ref_vid tracking", ref_vid, exp_ref(ramp_lvl));
            end
        end
        chk(seen, "R7 active done seen", seen, 1);
        req_off_n = 1;

        // R8: suspend request
        req_ram_n = 0; vid_rail_ok = 1;
        cyc();
        chk(!act_path_on && !vid_reg_en, "R8 sleep drops gate", act_path_on, 0);
        chk(ramp_lvl == 50, "R8 sleep park level", ramp_lvl, 50);
        chk(vid_pgood == 0, "R9 pg falls with enable", vid_pgood, 0);
        repeat (20) cyc();
        chk(vid_pgood == 0, "R9 pg held low while disabled", vid_pgood, 0);

        // R8: main supply loss during active ramp
        req_ram_n = 1;
        n = 0;
        while (!act_path_on && n < 5000) begin
            cyc();
            n++;
        end
        chk(n == Q + 1, "R6 second wake timing", n, Q + 1);
        repeat (5) cyc();
        main_pwr_ok = 0;
        cyc();
        chk(!act_path_on && ramp_lvl == 50, "R8 main loss forces standby", act_path_on, 0);

        // R10: shutdown and restart
        ss_hold = 1;
        cyc();
        chk(ramp_lvl == 0 && !act_path_on && !vid_pgood, "R10 shutdown ramp zero", ramp_lvl, 0);
        chk(ref_stby == 0 && ref_rest == 0 && ref_vid == 0, "R10 shutdown references", ref_stby, 0);
        repeat (5) cyc();
        chk(ramp_lvl == 0, "R10 held at zero", ramp_lvl, 0);
        ss_hold = 0;
        run_phase1("R10");

        repeat (10) cyc();
        chk(bad11 == 0, "R11 strobe exclusivity", bad11, 0);
        finish_run();
    end

endmodule